// File: doc/BRIEF.md
# Audio Master Clock Divider Generator

This block turns a master clock into the serial-port bit clock and frame clock of an audio capture interface. A 3-bit multiplier code picks a factor M from the set 1, 2, 3, 4, 6. A 3-bit rate-range code divides the fixed 512-cycle base ratio by a power of two. Together they fix the frame length in master-clock cycles. The number of slots per frame and the bit clocks per slot (16 or 32) set how many bit clocks fill that frame. The divide ratio between master clock and bit clock then follows from these settings.

The block checks the whole setting. It raises a configuration-error flag when any of these holds:
- a code is reserved;
- the frame cannot be split into a whole number of bit clocks of at least two master cycles each;
- the bit clock would run faster than its ceiling.

The frame clock comes either as a 50% wave or as a one-bit-clock pulse at the start of each frame. A new setting takes effect only at a frame boundary, so a running frame always completes. When the frame clock is the reference rather than the master clock, the block drives neither clock and checks only the rate code.

Top module: `aud_clkgen`

## Requirements
- R1: Multiplier code values 0, 1, 2, 3 and 4 select M = 1, 2, 3, 4 and 6. Codes 5, 6 and 7 set `cfg_bad_o`.
- R2: The frame lasts 512·M / 2^r master cycles, where r is the rate code (0 to 4). A rate code above 4 sets `cfg_bad_o`.
- R3: The number of slots per frame is 2, 4, 8 or 16 for `slot_sel_i` = 0, 1, 2 or 3. The bit clocks per slot are 16 when `bclk16_i`=1 and 32 when it is 0. One bit clock period N equals the frame length divided by slots × bits per slot.
- R4: The setting is flagged as bad when the frame length is not a whole multiple of the bit clocks per frame, or when N < 2.
- R5: The setting is flagged as bad when MCLK_HZ / N exceeds 24 576 000 Hz. With the default MCLK_HZ of 61 440 000, N = 2 is flagged and N = 3 is accepted.
- R6: Each bit clock period is low for floor(N/2) master cycles and then high for the rest. For odd N the two halves therefore differ by one master cycle.
- R7: With `pulse_i`=0, the frame clock is low for the first half of the frame's bit clocks and high for the second half. It changes only together with a falling bit clock edge.
- R8: With `pulse_i`=1, the frame clock is high for exactly the first bit clock of each frame.
- R9: With `ref_lr_i`=1, both clock outputs stay low. The multiplier code is ignored, and only the rate code can set `cfg_bad_o`.
- R10: While the active setting is bad, `bclk_o` and `lrclk_o` stay low and `cfg_bad_o` is high.
- R11: While clocks run, new inputs are taken only at the end of the current frame. While stopped, inputs are taken every cycle: `cfg_bad_o` follows one cycle later, and a good setting starts a new frame at once, with the bit clock low first.
- R12: During reset, `bclk_o`, `lrclk_o` and `cfg_bad_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mult_sel_i | input | 3 | Master-clock multiplier code |
| rate_sel_i | input | 3 | Sample-rate range code |
| bclk16_i | input | 1 | 1: 16 bit clocks per slot, 0: 32 |
| slot_sel_i | input | 2 | Slot count code (2, 4, 8, 16) |
| pulse_i | input | 1 | 1: pulse frame clock, 0: 50% frame clock |
| ref_lr_i | input | 1 | 1: frame clock is the reference, outputs idle |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| cfg_bad_o | output | 1 | Active setting is not allowed |

## Verification
A wrong divide ratio or a miscounted bit index shows within one bit clock period. It appears as a high or low run of the wrong length, and as a frame clock whose period or high time is off by whole bit clocks by the end of that frame. A setting taken outside a frame boundary shows as a shortened frame: the spacing between frame clock edges around the change is not the sum of the old and new half-frames. A missed legality check shows within a frame as clocks that keep running while the error flag should be high, or as a flag raised on a legal setting.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

  // Ratio-relevant part of the request; pulse shape is handled separately.
  typedef struct packed {
    logic [2:0] mult_sel;
    logic [2:0] rate_sel;
    logic       bclk16;
    logic [1:0] slot_sel;
    logic       ref_lr;
  } ratio_req_t;

  // Multiplier factor; 0 marks a reserved code.
  function automatic int unsigned mult_of(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      3'd4:    return 6;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned slots_of(input logic [1:0] code);
    return 32'd2 << code;
  endfunction

  // Master-clock cycles per frame.
  function automatic int unsigned frame_mclks(input int unsigned base,
                                              input int unsigned mult,
                                              input logic [2:0] rate);
    return (base * mult) >> rate;
  endfunction

endpackage

// File: rtl/aud_clkgen_ratio.sv
module aud_clkgen_ratio
  import aud_clkgen_pkg::*;
#(
  parameter int unsigned BASE_RATIO  = 512,
  parameter int unsigned MCLK_HZ     = 61_440_000,
  parameter int unsigned BCLK_MAX_HZ = 24_576_000,
  parameter int unsigned DIV_W       = 7,
  parameter int unsigned BPF_W       = 10
) (
  input  ratio_req_t       req_i,
  output logic [DIV_W-1:0] div_o,
  output logic [BPF_W-1:0] bpf_o,
  output logic             ok_o,
  output logic             drive_o
);

  logic [31:0] mult_w, flen_w, nbclk_w, ndiv_w;
  logic        rate_ok, mult_ok, fit_ok, speed_ok;

  assign mult_w  = mult_of(req_i.mult_sel);
  assign flen_w  = frame_mclks(BASE_RATIO, mult_w, req_i.rate_sel);
  assign nbclk_w = slots_of(req_i.slot_sel) * (req_i.bclk16 ? 32'd16 : 32'd32);
  assign ndiv_w  = flen_w / nbclk_w;

  assign rate_ok  = req_i.rate_sel <= 3'd4;
  assign mult_ok  = mult_w != 32'd0;
  assign fit_ok   = ((flen_w % nbclk_w) == 32'd0) && (ndiv_w >= 32'd2) &&
                    ((ndiv_w >> DIV_W) == 32'd0) && ((nbclk_w >> BPF_W) == 32'd0);
  assign speed_ok = 64'(MCLK_HZ) <= 64'(BCLK_MAX_HZ) * 64'(ndiv_w);

  assign ok_o    = rate_ok && (req_i.ref_lr || (mult_ok && fit_ok && speed_ok));
  assign drive_o = ok_o && !req_i.ref_lr;
  assign div_o   = ndiv_w[DIV_W-1:0];
  assign bpf_o   = nbclk_w[BPF_W-1:0];

endmodule

// File: rtl/aud_clkgen_seq.sv
module aud_clkgen_seq #(
  parameter int unsigned DIV_W = 7,
  parameter int unsigned BPF_W = 10
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BPF_W-1:0] bpf_i,
  input  logic             pulse_i,
  input  logic             drive_i,
  input  logic             ok_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             bad_o
);

  logic             run_q, pulse_q, bad_q, bclk_q, lr_q;
  logic [DIV_W-1:0] div_q, mcnt_q;
  logic [BPF_W-1:0] bpf_q, bcnt_q;

  logic             run_d, pulse_d, bad_d, bclk_d, lr_d;
  logic [DIV_W-1:0] div_d, mcnt_d;
  logic [BPF_W-1:0] bpf_d, bcnt_d;

  // Named events for the assertions.
  logic mcnt_wrap, frame_end, take_cfg;

  assign mcnt_wrap = mcnt_q == (div_q - 1'b1);
  assign frame_end = run_q && mcnt_wrap && (bcnt_q == (bpf_q - 1'b1));
  assign take_cfg  = !run_q || frame_end;

  always_comb begin
    run_d   = run_q;
    div_d   = div_q;
    bpf_d   = bpf_q;
    pulse_d = pulse_q;
    bad_d   = bad_q;
    mcnt_d  = mcnt_q + 1'b1;
    bcnt_d  = bcnt_q;
    if (take_cfg) begin
      run_d   = drive_i;
      div_d   = div_i;
      bpf_d   = bpf_i;
      pulse_d = pulse_i;
      bad_d   = !ok_i;
      mcnt_d  = '0;
      bcnt_d  = '0;
    end else if (mcnt_wrap) begin
      mcnt_d = '0;
      bcnt_d = bcnt_q + 1'b1;
    end
  end

  // Outputs are registered from next state so that they never glitch.
  assign bclk_d = run_d && (mcnt_d >= (div_d >> 1));
  assign lr_d   = run_d && (pulse_d ? (bcnt_d == '0) : (bcnt_d >= (bpf_d >> 1)));

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      div_q   <= '0;
      bpf_q   <= '0;
      pulse_q <= 1'b0;
      bad_q   <= 1'b0;
      mcnt_q  <= '0;
      bcnt_q  <= '0;
      bclk_q  <= 1'b0;
      lr_q    <= 1'b0;
    end else begin
      run_q   <= run_d;
      div_q   <= div_d;
      bpf_q   <= bpf_d;
      pulse_q <= pulse_d;
      bad_q   <= bad_d;
      mcnt_q  <= mcnt_d;
      bcnt_q  <= bcnt_d;
      bclk_q  <= bclk_d;
      lr_q    <= lr_d;
    end
  end

  assign bclk_o  = bclk_q;
  assign lrclk_o = lr_q;
  assign bad_o   = bad_q;

  AST_LR_ON_BCLK_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
    (run_q && $past(run_q) && (lr_q != $past(lr_q))) |-> $fell(bclk_q)); // R7

  AST_PULSE_ONE_BCLK: assert property (@(posedge mclk) disable iff (!rst_n)
    (run_q && pulse_q && $past(pulse_q) && lr_q && $past(lr_q)) |-> !$fell(bclk_q)); // R8

  AST_BAD_HALTS: assert property (@(posedge mclk) disable iff (!rst_n)
    bad_q |-> (!bclk_q && !lr_q)); // R10

  AST_CFG_FROZEN: assert property (@(posedge mclk) disable iff (!rst_n)
    (run_q && !frame_end) |=> ($stable(div_q) && $stable(bpf_q) && $stable(pulse_q))); // R11

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter int unsigned BASE_RATIO  = 512,
  parameter int unsigned MCLK_HZ     = 61_440_000,
  parameter int unsigned BCLK_MAX_HZ = 24_576_000,
  parameter int unsigned MAX_MULT    = 6,
  parameter int unsigned MIN_BCLKS   = 32,
  parameter int unsigned MAX_BCLKS   = 512
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [2:0] mult_sel_i,
  input  logic [2:0] rate_sel_i,
  input  logic       bclk16_i,
  input  logic [1:0] slot_sel_i,
  input  logic       pulse_i,
  input  logic       ref_lr_i,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       cfg_bad_o
);

  localparam int unsigned DIV_W = $clog2(BASE_RATIO * MAX_MULT / MIN_BCLKS + 1);
  localparam int unsigned BPF_W = $clog2(MAX_BCLKS + 1);

  ratio_req_t       req;
  logic [DIV_W-1:0] div_w;
  logic [BPF_W-1:0] bpf_w;
  logic             ok_w, drive_w;

  assign req = '{mult_sel: mult_sel_i, rate_sel: rate_sel_i, bclk16: bclk16_i,
                 slot_sel: slot_sel_i, ref_lr: ref_lr_i};

  aud_clkgen_ratio #(
    .BASE_RATIO (BASE_RATIO),
    .MCLK_HZ    (MCLK_HZ),
    .BCLK_MAX_HZ(BCLK_MAX_HZ),
    .DIV_W      (DIV_W),
    .BPF_W      (BPF_W)
  ) u_ratio (
    .req_i  (req),
    .div_o  (div_w),
    .bpf_o  (bpf_w),
    .ok_o   (ok_w),
    .drive_o(drive_w)
  );

  aud_clkgen_seq #(
    .DIV_W(DIV_W),
    .BPF_W(BPF_W)
  ) u_seq (
    .mclk   (mclk),
    .rst_n  (rst_n),
    .div_i  (div_w),
    .bpf_i  (bpf_w),
    .pulse_i(pulse_i),
    .drive_i(drive_w),
    .ok_i   (ok_w),
    .bclk_o (bclk_o),
    .lrclk_o(lrclk_o),
    .bad_o  (cfg_bad_o)
  );

  AST_IDLE_IN_REF: assert property (@(posedge mclk) disable iff (!rst_n)
    ($past(ref_lr_i) && ref_lr_i && $past(cfg_bad_o) && cfg_bad_o) |-> (!bclk_o && !lrclk_o)); // R9

endmodule

// File: tb/aud_clkgen_tb.sv
module aud_clkgen_tb;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mult_sel = 3'd1;
  logic [2:0] rate_sel = 3'd2;
  logic       bclk16 = 1'b0;
  logic [1:0] slot_sel = 2'd0;
  logic       pulse = 1'b0;
  logic       ref_lr = 1'b0;
  logic       bclk, lrclk, cfg_bad;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int cur_frame = 0;
  bit done = 0;

  always #5 mclk = ~mclk;

  aud_clkgen u_dut (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .mult_sel_i(mult_sel),
    .rate_sel_i(rate_sel),
    .bclk16_i  (bclk16),
    .slot_sel_i(slot_sel),
    .pulse_i   (pulse),
    .ref_lr_i  (ref_lr),
    .bclk_o    (bclk),
    .lrclk_o   (lrclk),
    .cfg_bad_o (cfg_bad)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge mclk);
    cyc++;
  endtask

  // Bench model of the ratio: master cycles per bit clock.
  function automatic int exp_div(input int m, input int r, input int s, input bit b16);
    int frame;
    int nb;
    frame = (512 * m) / (1 << r);
    nb = (1 << (s + 1)) * (b16 ? 16 : 32);
    return frame / nb;
  endfunction

  task automatic apply(input int m, input int r, input bit b16, input int s,
                       input bit p, input bit rl, input int new_frame);
    int settle;
    settle = cur_frame + 16;
    mult_sel = 3'(m); rate_sel = 3'(r); bclk16 = b16;
    slot_sel = 2'(s); pulse = p; ref_lr = rl;
    repeat (settle) step();
    cur_frame = new_frame;
  endtask

  task automatic wait_rise(input bit on_lr);
    logic prev;
    prev = on_lr ? lrclk : bclk;
    for (int i = 0; i < 8000; i++) begin
      step();
      if (!prev && (on_lr ? lrclk : bclk)) return;
      prev = on_lr ? lrclk : bclk;
    end
  endtask

  task automatic measure(input bit on_lr, output int hi, output int lo);
    wait_rise(on_lr);
    hi = 0; lo = 0;
    while ((on_lr ? lrclk : bclk) === 1'b1 && hi < 8000) begin hi++; step(); end
    while ((on_lr ? lrclk : bclk) === 1'b0 && lo < 8000) begin lo++; step(); end
  endtask

  task automatic quiet_for(input string req, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (bclk || lrclk) seen++;
    end
    check(req, "clock activity while idle", seen, 0);
  endtask

  task automatic t_reset();
    repeat (5) step();
    check("R12", "bclk in reset", bclk, 0);
    check("R12", "lrclk in reset", lrclk, 0);
    check("R12", "flag in reset", cfg_bad, 0);
    rst_n = 1'b1;
    cur_frame = 256;
  endtask

  task automatic t_mult_codes();
    int hi, lo, m;
    for (int c = 0; c < 5; c++) begin
      m = (c == 4) ? 6 : c + 1;
      apply(c, 2, 1'b1, 0, 1'b0, 1'b0, 128 * m);
      check("R1", "flag legal code", cfg_bad, 0);
      measure(1'b0, hi, lo);
      check("R1", "bclk period", hi + lo, exp_div(m, 2, 0, 1'b1));
      measure(1'b1, hi, lo);
      check("R1", "frame length", hi + lo, 128 * m);
    end
    for (int c = 5; c < 8; c++) begin
      apply(c, 2, 1'b1, 0, 1'b0, 1'b0, 0);
      check("R1", "flag reserved code", cfg_bad, 1);
    end
  endtask

  task automatic t_rate_codes();
    int hi, lo;
    for (int r = 0; r < 5; r++) begin
      apply(3, r, 1'b1, 0, 1'b0, 1'b0, 2048 >> r);
      measure(1'b1, hi, lo);
      check("R2", "frame length per rate code", hi + lo, 2048 >> r);
    end
    apply(0, 6, 1'b1, 0, 1'b0, 1'b0, 0);
    check("R2", "flag rate code 6", cfg_bad, 1);
  endtask

  task automatic t_slot_width();
    int hi, lo;
    apply(2, 2, 1'b1, 1, 1'b0, 1'b0, 384);
    measure(1'b0, hi, lo);
    check("R3", "bclk period 4 slots x16", hi + lo, exp_div(3, 2, 1, 1'b1));
    apply(2, 2, 1'b0, 1, 1'b0, 1'b0, 384);
    measure(1'b0, hi, lo);
    check("R3", "bclk period 4 slots x32", hi + lo, exp_div(3, 2, 1, 1'b0));
    apply(2, 2, 1'b1, 2, 1'b0, 1'b0, 384);
    measure(1'b0, hi, lo);
    check("R3", "bclk period 8 slots x16", hi + lo, 3);
    measure(1'b1, hi, lo);
    check("R3", "frame length 8 slots", hi + lo, 384);
  endtask

  task automatic t_ratio_limits();
    apply(2, 2, 1'b1, 3, 1'b0, 1'b0, 0);
    check("R4", "flag non-integer ratio", cfg_bad, 1);
    apply(0, 4, 1'b1, 0, 1'b0, 1'b0, 0);
    check("R4", "flag ratio one", cfg_bad, 1);
    apply(2, 4, 1'b0, 0, 1'b0, 1'b0, 0);
    check("R4", "flag ratio 1.5", cfg_bad, 1);
    apply(0, 3, 1'b1, 0, 1'b0, 1'b0, 0);
    check("R5", "flag bclk over ceiling (N=2)", cfg_bad, 1);
    apply(2, 4, 1'b1, 0, 1'b0, 1'b0, 96);
    check("R5", "flag bclk under ceiling (N=3)", cfg_bad, 0);
  endtask

  task automatic t_duty();
    int hi, lo;
    apply(2, 4, 1'b1, 0, 1'b0, 1'b0, 96);
    measure(1'b0, hi, lo);
    check("R6", "N=3 high run", hi, 2);
    check("R6", "N=3 low run", lo, 1);
    apply(4, 3, 1'b1, 1, 1'b0, 1'b0, 384);
    measure(1'b0, hi, lo);
    check("R6", "N=6 high run", hi, 3);
    check("R6", "N=6 low run", lo, 3);
  endtask

  task automatic t_lr_modes();
    int hi, lo;
    apply(4, 3, 1'b1, 1, 1'b0, 1'b0, 384);
    measure(1'b1, hi, lo);
    check("R7", "50% frame high half", hi, 192);
    check("R7", "50% frame low half", lo, 192);
    apply(1, 2, 1'b0, 0, 1'b1, 1'b0, 256);
    measure(1'b1, hi, lo);
    check("R8", "pulse width one bclk", hi, 4);
    check("R8", "pulse frame length", hi + lo, 256);
  endtask

  task automatic t_ref_source();
    apply(7, 2, 1'b1, 0, 1'b0, 1'b1, 0);
    check("R9", "flag with ref and reserved mult", cfg_bad, 0);
    quiet_for("R9", 300);
    apply(0, 5, 1'b1, 0, 1'b0, 1'b1, 0);
    check("R9", "flag with ref and bad rate", cfg_bad, 1);
  endtask

  task automatic t_halt_restart();
    int n;
    apply(1, 2, 1'b0, 0, 1'b0, 1'b0, 256);
    check("R11", "flag before change", cfg_bad, 0);
    mult_sel = 3'd6;
    step();
    check("R11", "flag held while frame runs", cfg_bad, 0);
    repeat (300) step();
    check("R10", "flag after bad setting", cfg_bad, 1);
    quiet_for("R10", 200);
    mult_sel = 3'd1;
    step();
    check("R11", "flag one cycle after good setting", cfg_bad, 0);
    n = 1;
    while (!bclk && n < 100) begin step(); n++; end
    check("R11", "cycles to first bclk high", n, 3);
    cur_frame = 256;
  endtask

  task automatic t_change_boundary();
    int r1, r2, r3;
    apply(1, 2, 1'b0, 0, 1'b0, 1'b0, 256);
    wait_rise(1'b1);
    r1 = cyc;
    repeat (5) step();
    mult_sel = 3'd2; rate_sel = 3'd4; bclk16 = 1'b1;
    wait_rise(1'b1);
    r2 = cyc;
    wait_rise(1'b1);
    r3 = cyc;
    check("R11", "edge spacing across change", r2 - r1, 128 + 48);
    check("R11", "frame after change", r3 - r2, 96);
    cur_frame = 96;
  endtask

  initial begin
    repeat (190000) @(posedge mclk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    t_mult_codes();
    t_rate_codes();
    t_slot_width();
    t_ratio_limits();
    t_duty();
    t_lr_modes();
    t_ref_source();
    t_halt_restart();
    t_change_boundary();
    done = 1;
    summary();
    $finish;
  end

endmodule